// File: doc/BRIEF.md
# Flash busy-status flag generator

This block produces the status byte that a NOR-style flash returns while an internal program or erase algorithm is running. A command port takes program, sector erase, erase suspend, erase resume and reset requests. A read port takes a strobe and a sector number and answers one cycle later with either a status byte (while busy) or the last result byte (while idle). The status byte is built from these flags:

- a data-polling bit;
- two toggle bits that follow different rules;
- a timeout flag;
- an erase-window flag.

Host software can tell from these flags which of the following is under way: a program, an erase, a suspended erase, or a program inside a suspended erase. The flags also show whether an operation has failed.

The algorithm itself is abstracted. A pulse counter stands in for progress. A program needs a fixed number of pulses. An erase needs a fixed number of pulses per selected sector. Any operation whose pulse demand passes the pulse limit ends in a failed state, and only a reset command leaves it. The block does not store array contents. A program command therefore carries the current content of the target cell, so that the block can decide whether the new data can be written without an erase.

Top module: `nor_busy_status`

## Requirements
- R1: A read strobe gives `rd_valid` high in the next cycle, with `rd_data` holding the status byte. The status byte layout is:
  - bit 7: data polling
  - bit 6: toggle A
  - bit 5: timeout
  - bit 3: erase window
  - bit 2: toggle B
  - bits 4, 1 and 0: always 0

  While idle, a read returns the last result byte instead of the status byte. That byte is 0xFF after reset or after an erase, and the programmed byte after a program.
- R2: A program command (`cmd_op` = 1) that can be written reads bit 7 as the complement of bit 7 of its data. It completes after PROG_PULSES cycles, and idle reads then return the programmed byte.
- R3: A program that would need any bit to go from 0 to 1 (a data bit is 1 where `cmd_cur` is 0) never completes. Bit 6 keeps toggling, and after PULSE_LIMIT cycles the block enters the failed state.
- R4: In the failed state, reads return:
  - bit 5 = 1;
  - bit 6 still toggling;
  - bit 7 = the complement of the target's bit 7 after a program failure, or 0 after an erase failure.

  Every command except reset is ignored in this state. Reset returns the block to idle.
- R5: The first sector erase command (`cmd_op` = 2) opens an acceptance window of WIN_CYCLES cycles, during which bit 3 reads 0. The erase then runs with bit 3 = 1 and takes ERASE_PULSES cycles per selected sector. A total above PULSE_LIMIT fails. A completed erase leaves idle reads at 0xFF.
- R6: Sector erase commands issued while the window is open add their sector to the selected set. Once the window has closed, such commands are ignored.
- R7: In the window, running and suspend-read states, bit 2 flips on every read addressed to a selected sector. It holds on reads of any other sector.
- R8: An erase suspend command (`cmd_op` = 3) issued while an erase is running enters suspend-read. In that state:
  - bit 6 holds;
  - bit 2 toggles on reads of suspended sectors.

  Erase resume (`cmd_op` = 4) continues the erase from where it stopped.
- R9: A program command in suspend-read enters suspend-program. In that state:
  - bit 6 toggles;
  - bit 7 is the complement of the data's bit 7;
  - bit 2 reads 1 for sectors outside the selected set.

  On completion the block returns to suspend-read.
- R10: Bit 6 flips on every read in the program, window, running-erase, suspend-program and failed states, and holds otherwise. Both toggle bits are 0 after `rst`.
- R11: The reset command (`cmd_op` = 5) returns the block to idle from any state and clears the selected-sector set. Codes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code: 1 program, 2 sector erase, 3 suspend, 4 resume, 5 reset |
| cmd_sector | input | log2(NUM_SECTORS) | Sector for a sector erase |
| cmd_data | input | 8 | Byte to program |
| cmd_cur | input | 8 | Present cell content at the program target |
| rd_strobe | input | 1 | Read request |
| rd_sector | input | log2(NUM_SECTORS) | Sector addressed by the read |
| rd_valid | output | 1 | Read answer present |
| rd_data | output | 8 | Status byte or last result byte |

## Verification
The visible flags depend on three pieces of internal state: the operating mode, the selected-sector set and the two toggle registers. A wrong mode or a missed transition shows up on the first read after it, through a wrong bit 3, 5 or 7 or through a toggle that flips when it should hold. A sector wrongly added to or dropped from the selected set shows up on the second read of that sector, when bit 2 fails to flip or flips when it should hold. A wrong pulse count shows up later, as an early or missing return to idle, or a missing failure, observed with reads after the expected duration.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4,
    OP_RESET  = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PROG = 3'd1,
    ST_EWIN = 3'd2,
    ST_ERUN = 3'd3,
    ST_SRD  = 3'd4,
    ST_SPRG = 3'd5,
    ST_FAIL = 3'd6
  } st_e;

  localparam int B_POLL = 7;
  localparam int B_TGA  = 6;
  localparam int B_TOUT = 5;
  localparam int B_WIN  = 3;
  localparam int B_TGB  = 2;
endpackage

// File: rtl/nbs_pulse_ctr.sv
module nbs_pulse_ctr #(
  parameter int NW    = 8,
  parameter int LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic          never,
  input  logic [NW-1:0] need,
  output logic          done,
  output logic          expire
);
  localparam logic [NW-1:0] LIM = NW'(LIMIT);

  logic [NW-1:0] cnt;
  logic [NW-1:0] target;
  logic          fits;
  logic          hit;

  // an operation fits when it has a finite demand that stays within the limit
  assign fits   = !never && (need != '0) && (need <= LIM);
  assign target = fits ? need : LIM;
  assign hit    = run && (cnt == target - 1'b1);
  assign done   = hit && fits;
  assign expire = hit && !fits;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nbs_seq.sv
module nbs_seq
  import nbs_pkg::*;
#(
  parameter int NSEC         = 8,
  parameter int SW           = 3,
  parameter int WIN_CYCLES   = 32,
  parameter int PROG_PULSES  = 8,
  parameter int ERASE_PULSES = 20,
  parameter int PULSE_LIMIT  = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [SW-1:0]   cmd_sector,
  input  logic [7:0]      cmd_data,
  input  logic [7:0]      cmd_cur,
  output st_e             st,
  output logic [NSEC-1:0] mask,
  output logic [7:0]      prg_byte,
  output logic [7:0]      sprg_byte,
  output logic [7:0]      last_byte,
  output logic            fail_b7,
  output logic            prg_ok
);
  localparam int WW  = $clog2(WIN_CYCLES + 1);
  localparam int NW  = $clog2(ERASE_PULSES * NSEC + PULSE_LIMIT + PROG_PULSES + 2);
  localparam int PCW = $clog2(NSEC + 1);

  op_e op;
  logic is_reset, is_prog, is_se, is_susp, is_resume;
  logic blank_ok, sprg_ok, win_end;
  logic [NSEC-1:0] sel_oh;
  logic [WW-1:0]   win_cnt;
  logic [PCW-1:0]  nsel;
  logic [NW-1:0]   need_erase;

  assign op        = op_e'(cmd_op);
  assign is_reset  = cmd_valid && (op == OP_RESET);
  assign is_prog   = cmd_valid && (op == OP_PROG);
  assign is_se     = cmd_valid && (op == OP_SERASE);
  assign is_susp   = cmd_valid && (op == OP_SUSP);
  assign is_resume = cmd_valid && (op == OP_RESUME);

  // programming may only clear bits: a 1 over a stored 0 cannot be written
  assign blank_ok = ((~cmd_cur) & cmd_data) == 8'h00;
  assign win_end  = (st == ST_EWIN) && (win_cnt == WW'(WIN_CYCLES - 1));

  always_comb begin
    sel_oh = '0;
    sel_oh[cmd_sector] = 1'b1;
  end

  always_comb begin
    nsel = '0;
    for (int i = 0; i < NSEC; i++) nsel = nsel + PCW'(mask[i]);
  end

  assign need_erase = NW'(ERASE_PULSES) * NW'(nsel);

  // slot 0 times the main program or erase, slot 1 the program inside a suspend
  logic [1:0]    c_clr, c_run, c_never, c_done, c_exp;
  logic [NW-1:0] c_need [2];

  assign c_clr[0]   = ((st == ST_IDLE) && is_prog) || win_end;
  assign c_run[0]   = (st == ST_PROG) || (st == ST_ERUN);
  assign c_never[0] = (st == ST_PROG) && !prg_ok;
  assign c_need[0]  = (st == ST_PROG) ? NW'(PROG_PULSES) : need_erase;

  assign c_clr[1]   = (st == ST_SRD) && is_prog;
  assign c_run[1]   = (st == ST_SPRG);
  assign c_never[1] = !sprg_ok;
  assign c_need[1]  = NW'(PROG_PULSES);

  for (genvar g = 0; g < 2; g++) begin : g_ctr
    nbs_pulse_ctr #(.NW(NW), .LIMIT(PULSE_LIMIT)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .clr   (c_clr[g]),
      .run   (c_run[g]),
      .never (c_never[g]),
      .need  (c_need[g]),
      .done  (c_done[g]),
      .expire(c_exp[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mask      <= '0;
      prg_byte  <= 8'hFF;
      sprg_byte <= 8'hFF;
      last_byte <= 8'hFF;
      fail_b7   <= 1'b0;
      prg_ok    <= 1'b1;
      sprg_ok   <= 1'b1;
      win_cnt   <= '0;
    end else if (is_reset) begin
      st      <= ST_IDLE;
      mask    <= '0;
      win_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (is_prog) begin
            st       <= ST_PROG;
            prg_byte <= cmd_data;
            prg_ok   <= blank_ok;
          end else if (is_se) begin
            st      <= ST_EWIN;
            mask    <= sel_oh;
            win_cnt <= '0;
          end
        end
        ST_PROG: begin
          if (c_done[0]) begin
            st        <= ST_IDLE;
            last_byte <= prg_byte;
          end else if (c_exp[0]) begin
            st      <= ST_FAIL;
            fail_b7 <= ~prg_byte[7];
          end
        end
        ST_EWIN: begin
          win_cnt <= win_cnt + 1'b1;
          if (is_se)   mask <= mask | sel_oh;
          if (win_end) st   <= ST_ERUN;
        end
        ST_ERUN: begin
          if (c_done[0]) begin
            st        <= ST_IDLE;
            mask      <= '0;
            last_byte <= 8'hFF;
          end else if (c_exp[0]) begin
            st      <= ST_FAIL;
            fail_b7 <= 1'b0;
          end else if (is_susp) begin
            st <= ST_SRD;
          end
        end
        ST_SRD: begin
          if (is_resume) begin
            st <= ST_ERUN;
          end else if (is_prog) begin
            st        <= ST_SPRG;
            sprg_byte <= cmd_data;
            sprg_ok   <= blank_ok;
          end
        end
        ST_SPRG: begin
          if (c_done[1]) begin
            st        <= ST_SRD;
            last_byte <= sprg_byte;
          end else if (c_exp[1]) begin
            st      <= ST_FAIL;
            fail_b7 <= ~sprg_byte[7];
          end
        end
        ST_FAIL: ;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nbs_status_fmt.sv
module nbs_status_fmt
  import nbs_pkg::*;
#(
  parameter int NSEC = 8,
  parameter int SW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_strobe,
  input  logic [SW-1:0]   rd_sector,
  input  st_e             st,
  input  logic [NSEC-1:0] mask,
  input  logic            prg_b7,
  input  logic            sprg_b7,
  input  logic [7:0]      last_byte,
  input  logic            fail_b7,
  output logic            rd_valid,
  output logic [7:0]      rd_data
);
  logic tga, tgb;
  logic in_set, flip_a, flip_b;
  logic [7:0] val;

  assign in_set = mask[rd_sector];

  always_comb begin
    flip_a = st inside {ST_PROG, ST_EWIN, ST_ERUN, ST_SPRG, ST_FAIL};
    flip_b = in_set && (st inside {ST_EWIN, ST_ERUN, ST_SRD, ST_SPRG});
    val    = 8'h00;
    if (st == ST_IDLE) begin
      val = last_byte;
    end else begin
      case (st)
        ST_PROG: val[B_POLL] = ~prg_b7;
        ST_SPRG: val[B_POLL] = ~sprg_b7;
        ST_FAIL: val[B_POLL] = fail_b7;
        default: val[B_POLL] = 1'b0;
      endcase
      val[B_TGA]  = tga;
      val[B_TOUT] = (st == ST_FAIL);
      val[B_WIN]  = st inside {ST_ERUN, ST_SRD, ST_SPRG};
      val[B_TGB]  = ((st == ST_SPRG) && !in_set) ? 1'b1 : tgb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      tga      <= 1'b0;
      tgb      <= 1'b0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) begin
        rd_data <= val;
        if (flip_a) tga <= ~tga;
        if (flip_b) tgb <= ~tgb;
      end
    end
  end
endmodule

// File: rtl/nor_busy_status.sv
module nor_busy_status
  import nbs_pkg::*;
#(
  parameter int NUM_SECTORS  = 8,
  parameter int WIN_CYCLES   = 32,
  parameter int PROG_PULSES  = 8,
  parameter int ERASE_PULSES = 20,
  parameter int PULSE_LIMIT  = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cmd_valid,
  input  logic [2:0]                     cmd_op,
  input  logic [$clog2(NUM_SECTORS)-1:0] cmd_sector,
  input  logic [7:0]                     cmd_data,
  input  logic [7:0]                     cmd_cur,
  input  logic                           rd_strobe,
  input  logic [$clog2(NUM_SECTORS)-1:0] rd_sector,
  output logic                           rd_valid,
  output logic [7:0]                     rd_data
);
  localparam int SW = $clog2(NUM_SECTORS);

  st_e                    st;
  logic [NUM_SECTORS-1:0] mask;
  logic [7:0]             prg_byte, sprg_byte, last_byte;
  logic                   fail_b7, prg_ok;

  nbs_seq #(
    .NSEC(NUM_SECTORS), .SW(SW), .WIN_CYCLES(WIN_CYCLES),
    .PROG_PULSES(PROG_PULSES), .ERASE_PULSES(ERASE_PULSES), .PULSE_LIMIT(PULSE_LIMIT)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_data(cmd_data), .cmd_cur(cmd_cur),
    .st(st), .mask(mask), .prg_byte(prg_byte), .sprg_byte(sprg_byte),
    .last_byte(last_byte), .fail_b7(fail_b7), .prg_ok(prg_ok)
  );

  nbs_status_fmt #(.NSEC(NUM_SECTORS), .SW(SW)) u_fmt (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_sector(rd_sector),
    .st(st), .mask(mask), .prg_b7(prg_byte[7]), .sprg_b7(sprg_byte[7]),
    .last_byte(last_byte), .fail_b7(fail_b7),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/nbs_chk.sv
module nbs_chk
  import nbs_pkg::*;
#(
  parameter int NSEC       = 8,
  parameter int WIN_CYCLES = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input st_e             st,
  input logic [NSEC-1:0] mask,
  input logic            prg_ok,
  input logic            rd_strobe,
  input logic            rd_valid
);
  localparam int WLW = $clog2(WIN_CYCLES + 1) + 1;
  localparam logic [WLW-1:0] WLIM = WLW'(WIN_CYCLES);

  logic [WLW-1:0] wl;
  logic           rst_cmd, se_cmd;

  assign rst_cmd = cmd_valid && (cmd_op == OP_RESET);
  assign se_cmd  = cmd_valid && (cmd_op == OP_SERASE);

  always_ff @(posedge clk) begin
    if (rst)                         wl <= '0;
    else if (st == ST_EWIN && wl < WLIM) wl <= wl + 1'b1;
    else if (st != ST_EWIN)          wl <= '0;
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> rd_valid); // R1

  AST_NONBLANK_STUCK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && !prg_ok && !rst_cmd) |=> (st == ST_PROG || st == ST_FAIL)); // R3

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FAIL && !rst_cmd) |=> (st == ST_FAIL)); // R4

  AST_FAIL_ONLY_FROM_COUNTED: assert property (@(posedge clk) disable iff (rst)
    (st inside {ST_IDLE, ST_EWIN, ST_SRD}) |=> (st != ST_FAIL)); // R4

  AST_WINDOW_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EWIN) |-> (wl < WLIM)); // R5

  AST_LATE_ERASE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERUN && se_cmd) |=> (mask == $past(mask) || mask == '0)); // R6

  AST_RESET_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rst_cmd |=> (st == ST_IDLE && mask == '0)); // R11
endmodule

bind nor_busy_status nbs_chk #(.NSEC(NUM_SECTORS), .WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .st(st),
  .mask(mask), .prg_ok(prg_ok), .rd_strobe(rd_strobe), .rd_valid(rd_valid)
);

// File: tb/test_nor_busy_status.sv
`timescale 1ns/1ps
module test_nor_busy_status;
  localparam int NS = 8;
  localparam int MI = 0, MP = 1, MW = 2, MR = 3, MS = 4, MQ = 5, MF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_sector = 3'd0;
  logic [7:0] cmd_data = 8'h00, cmd_cur = 8'hFF;
  logic rd_strobe = 1'b0;
  logic [2:0] rd_sector = 3'd0;
  logic rd_valid;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] q_exp[$];
  string      q_req[$];

  // bench model of the flags, written from the requirements
  int mode = MI;
  logic m6 = 1'b0, m2 = 1'b0, f7 = 1'b0;
  logic [7:0] m_mask = 8'h00, pd = 8'hFF, spd = 8'hFF, last = 8'hFF;

  always #2 clk = ~clk;

  nor_busy_status #(.NUM_SECTORS(NS), .WIN_CYCLES(32), .PROG_PULSES(8),
                    .ERASE_PULSES(20), .PULSE_LIMIT(64)) i_nor_busy_status (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_data(cmd_data), .cmd_cur(cmd_cur),
    .rd_strobe(rd_strobe), .rd_sector(rd_sector),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic send(input logic [2:0] op, input logic [2:0] sec,
                      input logic [7:0] dat, input logic [7:0] cur);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = sec; cmd_data = dat; cmd_cur = cur;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic rd(input logic [2:0] sec, input string req);
    logic [7:0] e;
    logic in;
    @(negedge clk);
    in = m_mask[sec];
    e  = 8'h00;
    if (mode == MI) e = last;
    else begin
      if (mode == MP) e[7] = ~pd[7];
      else if (mode == MQ) e[7] = ~spd[7];
      else if (mode == MF) e[7] = f7;
      e[6] = m6;
      e[5] = (mode == MF);
      e[3] = (mode == MR || mode == MS || mode == MQ);
      e[2] = (mode == MQ && !in) ? 1'b1 : m2;
      if (mode == MP || mode == MW || mode == MR || mode == MQ || mode == MF) m6 = ~m6;
      if (in && (mode == MW || mode == MR || mode == MS || mode == MQ)) m2 = ~m2;
    end
    q_exp.push_back(e);
    q_req.push_back(req);
    rd_strobe = 1'b1; rd_sector = sec;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  // monitor: pops one expected byte per answered read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_chk++;
      if (q_exp.size() == 0) begin
        n_bad++;
        $display("FAIL R1: unrequested answer rd_data=%h expected no answer", rd_data);
      end else begin
        logic [7:0] e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s: rd_data=%h expected %h", r, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    n_chk++;
    if (rd_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rd_valid=%b after reset expected 0", rd_valid);
    end
    rd(3'd0, "R1 idle read after reset");

    // R2 writable program
    send(3'd1, 3'd0, 8'h5A, 8'hFF); mode = MP; pd = 8'h5A;
    rd(3'd0, "R2 polling during program");
    rd(3'd0, "R10 toggle A during program");
    repeat (20) @(negedge clk); mode = MI; last = 8'h5A;
    rd(3'd0, "R2 data after program");

    // R3 program over a cleared bit
    send(3'd1, 3'd0, 8'h01, 8'h00); mode = MP; pd = 8'h01;
    rd(3'd0, "R3 nonblank program busy");
    rd(3'd0, "R3 nonblank toggle A");
    repeat (80) @(negedge clk); mode = MF; f7 = 1'b1;
    rd(3'd0, "R3 timeout after nonblank program");
    send(3'd1, 3'd0, 8'h00, 8'hFF);
    rd(3'd0, "R4 program ignored while failed");
    send(3'd6, 3'd0, 8'h00, 8'hFF);
    rd(3'd0, "R11 unused code ignored");
    send(3'd5, 3'd0, 8'h00, 8'hFF); mode = MI; m_mask = 8'h00;
    rd(3'd0, "R4 reset command leaves failure");

    // R5-R9 erase with window, suspend and nested program
    send(3'd2, 3'd2, 8'h00, 8'hFF); mode = MW; m_mask = 8'h04;
    rd(3'd2, "R7 toggle B selected sector in window");
    rd(3'd2, "R5 window flag low while open");
    rd(3'd5, "R7 toggle B holds on other sector");
    send(3'd2, 3'd5, 8'h00, 8'hFF); m_mask = 8'h24;
    rd(3'd5, "R6 sector added in window");
    rd(3'd5, "R6 added sector toggles");
    repeat (30) @(negedge clk); mode = MR;
    rd(3'd2, "R5 window flag high while erasing");
    send(3'd2, 3'd7, 8'h00, 8'hFF);
    rd(3'd7, "R6 late erase command ignored");
    rd(3'd7, "R6 late sector not toggling");
    send(3'd3, 3'd0, 8'h00, 8'hFF); mode = MS;
    rd(3'd2, "R8 suspend read toggle B");
    rd(3'd2, "R8 suspend read toggle A holds");
    rd(3'd1, "R8 unsuspended sector holds");
    send(3'd1, 3'd0, 8'h3C, 8'hFF); mode = MQ; spd = 8'h3C;
    rd(3'd1, "R9 suspend program bit2 high");
    rd(3'd1, "R9 suspend program toggle A");
    rd(3'd2, "R9 suspended sector toggles");
    repeat (20) @(negedge clk); mode = MS;
    rd(3'd1, "R9 back to suspend read");
    send(3'd4, 3'd0, 8'h00, 8'hFF); mode = MR;
    repeat (60) @(negedge clk); mode = MI; m_mask = 8'h00; last = 8'hFF;
    rd(3'd2, "R5 erase completes after resume");

    // R5 erase over the pulse limit
    send(3'd2, 3'd0, 8'h00, 8'hFF); mode = MW; m_mask = 8'h01;
    send(3'd2, 3'd1, 8'h00, 8'hFF); m_mask = 8'h03;
    send(3'd2, 3'd2, 8'h00, 8'hFF); m_mask = 8'h07;
    send(3'd2, 3'd3, 8'h00, 8'hFF); m_mask = 8'h0F;
    repeat (140) @(negedge clk); mode = MF; f7 = 1'b0;
    rd(3'd0, "R5 erase timeout");
    rd(3'd1, "R4 failed toggle A");
    send(3'd5, 3'd0, 8'h00, 8'hFF); mode = MI; m_mask = 8'h00;
    rd(3'd0, "R11 reset after erase failure");

    // R11 selected set cleared by reset command
    send(3'd2, 3'd6, 8'h00, 8'hFF); mode = MW; m_mask = 8'h40;
    rd(3'd0, "R11 old sector not selected");
    rd(3'd0, "R11 old sector still not selected");
    send(3'd5, 3'd0, 8'h00, 8'hFF); mode = MI; m_mask = 8'h00;
    rd(3'd6, "R11 reset during window");

    repeat (4) @(negedge clk);
    n_chk++;
    if (q_exp.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d reads unanswered expected 0", q_exp.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule